// File: doc/BRIEF.md
# ALU Status Flag Generator

This block derives the condition flags of an arithmetic/logic unit from the two operands and the result of one operation, and keeps them in a flag register alongside three control flags. The arithmetic itself happens elsewhere. The block receives the operands, the finished result, an operation class and a width select. It then works out carry, parity, auxiliary carry, zero, sign and overflow at byte or word width and loads them into the register on the next clock edge.

The three control flags are trap, interrupt enable and direction. They are written only by an explicit set or clear command, which arrives on its own small command port. An ALU result never changes them. A command and an ALU update may land in the same cycle, and both then take effect. The stored state is presented as one 16-bit flag word. Unused positions in that word read as zero.

Top module: `flagUnit`

## Requirements
- R1: An active-low reset `rstN` clears every bit of `flags` to 0. The reset is asynchronous, and `flags` stays 0 for as long as reset is held.
- R2: Carry sits at bit 0. For an add (`opClass`=2'b00) it is set when there is a carry out of the top bit of the selected width. For a subtract (`opClass`=2'b01) it is set when there is a borrow into that bit. A carry-in or borrow-in folded into `result` counts toward this flag.
- R3: Parity sits at bit 2. It is set when `result[7:0]` holds an even number of ones, whatever the selected width.
- R4: Auxiliary carry sits at bit 4. For an add it is set on a carry from bit 3 into bit 4. For a subtract it is set on a borrow from bit 4 into bit 3.
- R5: Zero sits at bit 6. It is set exactly when the result is zero at the selected width. With `wordSel`=0 only `result[7:0]` counts; with `wordSel`=1 all 16 bits count.
- R6: Sign sits at bit 7. It takes the top bit of the result at the selected width: bit 7 for a byte, bit 15 for a word.
- R7: Overflow sits at bit 11. It is set when the signed result of an add or subtract does not fit in the selected width.
- R8: A logical operation (`opClass`=2'b10) clears carry, overflow and auxiliary carry. It still sets zero, sign and parity from the result.
- R9: Trap (bit 8), interrupt enable (bit 9) and direction (bit 10) change only when `ctlValid`=1. `ctlSel` picks the flag: 0 is trap, 1 is interrupt enable, 2 is direction, and 3 selects nothing. `ctlSet`=1 sets the chosen flag and `ctlSet`=0 clears it.
- R10: `opClass`=2'b11 leaves the condition flags (bits 0, 2, 4, 6, 7, 11) unchanged. Bits 1, 3, 5 and 15:12 of `flags` always read 0.
- R11: An ALU update and a control command presented in the same cycle both appear in `flags` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opClass | input | 2 | 00 add, 01 subtract, 10 logical, 11 no condition update |
| wordSel | input | 1 | 1 selects word width, 0 selects byte width |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand (subtrahend for a subtract) |
| result | input | DATA_W | Result produced by the ALU |
| ctlValid | input | 1 | A control flag command is present |
| ctlSel | input | 2 | Control flag to change: 0 trap, 1 interrupt enable, 2 direction, 3 none |
| ctlSet | input | 1 | 1 sets the selected control flag, 0 clears it |
| flags | output | 16 | Registered flag word |

## Verification
The bench builds the block with its defaults: 16-bit words, an 8-bit parity field and a 4-bit nibble. With those values, byte and word widths can be compared on the same operands. For example, a byte result whose upper byte is nonzero must still raise zero. A word result with bits set above bit 7 must still take its parity from the low byte. Signed limits at both 0x7F/0x80 and 0x7FFF/0x8000, together with carry-in and borrow-in folded into the result, test carry, overflow and nibble borrow at each width.

// File: rtl/flagPkg.sv
package flagPkg;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_LOGIC = 2'b10,
    OP_HOLD  = 2'b11
  } opClass_e;

  localparam int FLAG_W = 16;
  localparam int CTL_N  = 3;

  // positions inside the flag word
  localparam int CF_POS  = 0;
  localparam int PF_POS  = 2;
  localparam int AF_POS  = 4;
  localparam int ZF_POS  = 6;
  localparam int SF_POS  = 7;
  localparam int CTL_POS = 8;   // trap, interrupt enable, direction upward
  localparam int OF_POS  = 11;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadCond;
    logic             subOp;
    logic             logicOp;
    logic [CTL_N-1:0] setCtl;
    logic [CTL_N-1:0] clrCtl;
  } flagStrb_t;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } condFlags_t;

endpackage

// File: rtl/flagCtrl.sv
module flagCtrl
  import flagPkg::*;
(
  input  logic [1:0] opClass,
  input  logic       ctlValid,
  input  logic [1:0] ctlSel,
  input  logic       ctlSet,
  output flagStrb_t  strb
);

  opClass_e opCls;

  always_comb begin
    opCls         = opClass_e'(opClass);
    strb          = '0;
    strb.loadCond = (opCls != OP_HOLD);
    strb.subOp    = (opCls == OP_SUB);
    strb.logicOp  = (opCls == OP_LOGIC);
    for (int i = 0; i < CTL_N; i++) begin
      strb.setCtl[i] = ctlValid &&  ctlSet && (ctlSel == 2'(i));
      strb.clrCtl[i] = ctlValid && !ctlSet && (ctlSel == 2'(i));
    end
  end

endmodule

// File: rtl/flagCalc.sv
module flagCalc
  import flagPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAR_W  = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] result,
  input  logic              wordSel,
  input  flagStrb_t         strb,
  output condFlags_t        condNext
);

  localparam int LOW_W = DATA_W / 2;

  logic [DATA_W-1:0] carryVec;
  logic [DATA_W-1:0] ovVec;
  logic              topCarry;
  logic              topOv;
  logic              unusedVec;

  // carry/borrow out of each bit, recovered from operands and result
  always_comb begin
    if (strb.subOp) begin
      carryVec = (~opA & opB) | ((~opA | opB) & result);
      ovVec    = (opA ^ opB) & (opA ^ result);
    end else begin
      carryVec = (opA & opB) | ((opA | opB) & ~result);
      ovVec    = ~(opA ^ opB) & (opA ^ result);
    end
  end

  assign unusedVec = ^{carryVec, ovVec};

  always_comb begin
    topCarry    = wordSel ? carryVec[DATA_W-1] : carryVec[LOW_W-1];
    topOv       = wordSel ? ovVec[DATA_W-1]    : ovVec[LOW_W-1];
    condNext.cf = strb.logicOp ? 1'b0 : topCarry;
    condNext.of = strb.logicOp ? 1'b0 : topOv;
    condNext.af = strb.logicOp ? 1'b0 : carryVec[NIB_W-1];
    condNext.pf = ~^result[PAR_W-1:0];
    condNext.zf = wordSel ? (result == '0) : (result[LOW_W-1:0] == '0);
    condNext.sf = wordSel ? result[DATA_W-1] : result[LOW_W-1];
  end

endmodule

// File: rtl/flagRegs.sv
module flagRegs
  import flagPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrb_t         strb,
  input  condFlags_t        condNext,
  output logic [FLAG_W-1:0] flags
);

  condFlags_t       condQ;
  logic [CTL_N-1:0] ctlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              condQ <= '0;
    else if (strb.loadCond) condQ <= condNext;
  end

  for (genvar g = 0; g < CTL_N; g++) begin : g_ctl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                ctlQ[g] <= 1'b0;
      else if (strb.setCtl[g])  ctlQ[g] <= 1'b1;
      else if (strb.clrCtl[g])  ctlQ[g] <= 1'b0;
    end
  end

  always_comb begin
    flags                   = '0;
    flags[CF_POS]           = condQ.cf;
    flags[PF_POS]           = condQ.pf;
    flags[AF_POS]           = condQ.af;
    flags[ZF_POS]           = condQ.zf;
    flags[SF_POS]           = condQ.sf;
    flags[OF_POS]           = condQ.of;
    flags[CTL_POS +: CTL_N] = ctlQ;
  end

endmodule

// File: rtl/flagUnit.sv
module flagUnit
  import flagPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAR_W  = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opClass,
  input  logic              wordSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] result,
  input  logic              ctlValid,
  input  logic [1:0]        ctlSel,
  input  logic              ctlSet,
  output logic [15:0]       flags
);

  flagStrb_t  strb;
  condFlags_t condNext;

  flagCtrl u_ctrl (
    .opClass  (opClass),
    .ctlValid (ctlValid),
    .ctlSel   (ctlSel),
    .ctlSet   (ctlSet),
    .strb     (strb)
  );

  flagCalc #(
    .DATA_W (DATA_W),
    .PAR_W  (PAR_W),
    .NIB_W  (NIB_W)
  ) u_calc (
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .wordSel  (wordSel),
    .strb     (strb),
    .condNext (condNext)
  );

  flagRegs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .condNext (condNext),
    .flags    (flags)
  );

endmodule

// File: rtl/flagUnitChk.sv
module flagUnitChk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        opClass,
  input logic              wordSel,
  input logic [DATA_W-1:0] result,
  input logic              ctlValid,
  input logic [15:0]       flags
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> flags == 16'h0000);

  // R3
  parity_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    opClass != 2'b11 |=> flags[2] == ~^$past(result[7:0]));

  // R5
  zero_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opClass != 2'b11 && wordSel && result == '0) |=> flags[6]);

  // R8
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    opClass == 2'b10 |=> (flags[0] == 1'b0 && flags[4] == 1'b0 && flags[11] == 1'b0));

  // R9
  ctl_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlValid |=> $stable(flags[10:8]));

  // R10
  cond_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    opClass == 2'b11 |=> $stable({flags[11], flags[7:6], flags[4], flags[2], flags[0]}));

  // R10
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[15:12] == 4'h0 && flags[5] == 1'b0 && flags[3] == 1'b0 && flags[1] == 1'b0);

endmodule

bind flagUnit flagUnitChk #(.DATA_W(DATA_W)) u_flagChk (
  .clk      (clk),
  .rstN     (rstN),
  .opClass  (opClass),
  .wordSel  (wordSel),
  .result   (result),
  .ctlValid (ctlValid),
  .flags    (flags)
);

// File: tb/test_flagUnit.sv
`timescale 1ns/1ps
module test_flagUnit;

  localparam logic [1:0] ADD = 2'b00, SUB = 2'b01, LOG = 2'b10, HLD = 2'b11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opClass = HLD;
  logic        wordSel = 1'b1;
  logic [15:0] opA = '0, opB = '0, result = '0;
  logic        ctlValid = 1'b0;
  logic [1:0]  ctlSel = 2'b11;
  logic        ctlSet = 1'b0;
  logic [15:0] flags;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sbQ[$];

  bit eCf, ePf, eAf, eZf, eSf, eOf;
  bit [2:0] eCtl;

  always #2.5 clk = ~clk;

  flagUnit i_flagUnit (
    .clk(clk), .rstN(rstN), .opClass(opClass), .wordSel(wordSel),
    .opA(opA), .opB(opB), .result(result),
    .ctlValid(ctlValid), .ctlSel(ctlSel), .ctlSet(ctlSet), .flags(flags)
  );

  function automatic logic [15:0] expWord();
    return {4'b0000, eOf, eCtl[2], eCtl[1], eCtl[0], eSf, eZf, 1'b0, eAf, 1'b0, ePf, 1'b0, eCf};
  endfunction

  task automatic step(input logic [1:0] cls, input bit ws, input logic [15:0] a,
                      input logic [15:0] b, input bit cin, input bit cv,
                      input logic [1:0] cs, input bit cset, input string tag);
    int w, mask, ua, ub, sa, sb, sres, smax, smin;
    logic [15:0] r;
    item_t it;
    w    = ws ? 16 : 8;
    mask = (1 << w) - 1;
    ua   = int'(a) & mask;
    ub   = int'(b) & mask;
    sa   = ws ? int'($signed(a)) : int'($signed(a[7:0]));
    sb   = ws ? int'($signed(b)) : int'($signed(b[7:0]));
    smax = (1 << (w - 1)) - 1;
    smin = -(1 << (w - 1));
    r    = a;
    if (cls == ADD) begin
      r    = 16'(a + b + 16'(cin));
      eCf  = (ua + ub + int'(cin)) > mask;
      eAf  = (int'(a[3:0]) + int'(b[3:0]) + int'(cin)) > 15;
      sres = sa + sb + int'(cin);
      eOf  = (sres > smax) || (sres < smin);
    end else if (cls == SUB) begin
      r    = 16'(a - b - 16'(cin));
      eCf  = ua < (ub + int'(cin));
      eAf  = int'(a[3:0]) < (int'(b[3:0]) + int'(cin));
      sres = sa - sb - int'(cin);
      eOf  = (sres > smax) || (sres < smin);
    end else if (cls == LOG) begin
      eCf = 0; eAf = 0; eOf = 0;
    end
    if (cls != HLD) begin
      eZf = (int'(r) & mask) == 0;
      eSf = r[w-1];
      ePf = ~^r[7:0];
    end
    if (cv && cs != 2'b11) eCtl[cs] = cset;
    @(negedge clk);
    opClass = cls; wordSel = ws; opA = a; opB = b; result = r;
    ctlValid = cv; ctlSel = cs; ctlSet = cset;
    it.exp = expWord();
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic direct(input logic [15:0] exp, input string tag);
    checks++;
    if (flags !== exp) begin
      bad++;
      $display("FAIL %s flags=%h expected=%h", tag, flags, exp);
    end
  endtask

  // monitor: pops one expected item per driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        checks++;
        if (flags !== it.exp) begin
          bad++;
          $display("FAIL %s flags=%h expected=%h", it.tag, flags, it.exp);
        end
      end
    end
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    direct(16'h0000, "R1 reset state");
    rstN = 1'b1;
    step(HLD, 1, 16'h0000, 16'h0000, 0, 0, 2'b11, 0, "R10 idle after reset");
    step(ADD, 1, 16'h7FFF, 16'h0001, 0, 0, 2'b11, 0, "R7 R6 word add overflow");
    step(ADD, 1, 16'hFFFF, 16'h0001, 0, 0, 2'b11, 0, "R2 R5 word add carry to zero");
    step(ADD, 0, 16'h12FF, 16'h0001, 0, 0, 2'b11, 0, "R5 R2 byte zero ignores upper byte");
    step(ADD, 1, 16'h0001, 16'h0001, 1, 0, 2'b11, 0, "R2 R3 add with carry-in");
    step(ADD, 1, 16'h0008, 16'h0008, 0, 0, 2'b11, 0, "R4 nibble carry");
    step(ADD, 0, 16'h007F, 16'h0001, 0, 0, 2'b11, 0, "R7 R6 byte add overflow");
    step(SUB, 1, 16'h0000, 16'h0001, 0, 0, 2'b11, 0, "R2 R4 word borrow");
    step(SUB, 1, 16'h8000, 16'h0001, 0, 0, 2'b11, 0, "R7 word sub overflow");
    step(SUB, 0, 16'h0050, 16'h0070, 0, 0, 2'b11, 0, "R2 R6 byte borrow and sign");
    step(SUB, 0, 16'h0080, 16'h0001, 0, 0, 2'b11, 0, "R7 byte sub overflow");
    step(SUB, 0, 16'h0010, 16'h0000, 1, 0, 2'b11, 0, "R4 R2 nibble borrow with borrow-in");
    step(SUB, 1, 16'h1234, 16'h1234, 0, 0, 2'b11, 0, "R5 word equal operands");
    step(LOG, 1, 16'h0103, 16'h0000, 0, 0, 2'b11, 0, "R3 parity on low byte only");
    step(ADD, 1, 16'hFFFF, 16'h0001, 0, 0, 2'b11, 0, "R2 carry before logic");
    step(LOG, 1, 16'h8000, 16'h0000, 0, 0, 2'b11, 0, "R8 R6 logic clears carry, word sign");
    step(LOG, 0, 16'hFF00, 16'h0000, 0, 0, 2'b11, 0, "R8 R5 byte logic zero");
    step(ADD, 1, 16'h7FFF, 16'h7FFF, 1, 0, 2'b11, 0, "R7 R4 overflow before hold");
    step(HLD, 0, 16'hA5A5, 16'h5A5A, 0, 0, 2'b11, 0, "R10 hold keeps condition flags");
    step(HLD, 1, 16'h0000, 16'hFFFF, 0, 1, 2'b00, 1, "R9 set trap");
    step(ADD, 1, 16'h0001, 16'h0002, 0, 1, 2'b01, 1, "R11 interrupt enable set with add");
    step(HLD, 1, 16'h0000, 16'h0000, 0, 1, 2'b10, 1, "R9 set direction");
    step(SUB, 1, 16'h0005, 16'h0005, 0, 1, 2'b01, 0, "R11 interrupt enable clear with sub");
    step(LOG, 1, 16'h0000, 16'h0000, 0, 1, 2'b11, 1, "R9 select 3 changes nothing");
    step(ADD, 1, 16'hFFFF, 16'hFFFF, 1, 0, 2'b00, 0, "R9 ALU result leaves control flags");
    step(HLD, 1, 16'h0000, 16'h0000, 0, 1, 2'b00, 0, "R9 clear trap");
    step(HLD, 1, 16'h0000, 16'h0000, 0, 0, 2'b11, 0, "R10 idle tail");
    wait (sbQ.size() == 0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    direct(16'h0000, "R1 asynchronous reset mid-run");
    @(negedge clk);
    direct(16'h0000, "R1 reset held");
    rstN = 1'b1;
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule